// File: doc/BRIEF.md
# Response Ring Dispatcher

This block drains an inbound ring of 256 response entries that a link receiver fills. Each entry is a pair of 32-bit words: a response word and an extended tag word. The receiver publishes a 16-bit write pointer. The dispatcher keeps its own 8-bit read pointer. Whenever the two differ, it fetches the entry that follows the read pointer, one entry per handshake, and routes that entry by its tag.

The tag is decoded in a fixed priority order:
- An entry with a bad codec address is reported as an error and has no other effect.
- An entry with the event flag set goes to a 16-deep unsolicited-event queue.
- Any other entry is a solicited answer. It is matched to its codec only through a per-codec outstanding-command counter. The command-issue side increments that counter, and each matched answer decrements it.

Software reads the latest stored answer for any codec. A codec's busy flag clears when its counter reaches zero. Software pops events through a stream port. Every consumed entry raises one interrupt pulse.

Top module: `resp_ring_dispatch`

## Requirements
- R1: After reset the read pointer is 0, all outstanding counters and stored results are 0, the event queue is empty, and no pulse output is high.
- R2: `fetch_valid` is high when `hw_wp` is not 0xFFFF, `ptr_clear` is low, and the read pointer differs from `hw_wp[7:0]`. `fetch_idx` is the read pointer plus one, modulo 256. On each cycle with `fetch_valid && fetch_ready` the entry on `fetch_resp`/`fetch_ext` is consumed, and the read pointer becomes `fetch_idx`, wrapping from 255 to 0.
- R3: While `hw_wp` equals 0xFFFF, no entry is fetched and the read pointer holds.
- R4: Bits 3:0 of the extended word are the codec address. An address of `NCODEC` (default 8) or more pulses `bad_addr_err` the cycle after consumption and changes no counter, result or queue, even when bit 4 is set.
- R5: With a valid address and bit 4 of the extended word set, the entry is queued as an event that carries the response word and the whole extended word. Events leave in arrival order on `evt_*`.
- R6: A solicited entry (bit 4 clear, valid address) whose codec counter is nonzero stores its response word as that codec's result and decrements the counter.
- R7: A solicited entry whose codec counter is zero before the consuming edge pulses `orphan_err` and leaves the result and the counter unchanged.
- R8: A `cmd_valid` cycle with `cmd_addr` below `NCODEC` increments that codec's counter. If the same codec's counter is also decremented in that cycle, it keeps its value. `busy[c]` is high exactly when counter c is nonzero.
- R9: `resp_irq` pulses for exactly one cycle, the cycle after each consumed entry, whatever the entry's class.
- R10: The event queue holds 16 entries. A push that arrives when the queue is already full before the edge is dropped, even if a pop happens in the same cycle, and `evt_drop` pulses the next cycle.
- R11: `ptr_clear` forces `fetch_valid` low in its cycle and sets the read pointer to 0, so that the next fetch index is 1.
- R12: `res_data` returns the stored result of codec `res_sel`, or 0 when `res_sel` is `NCODEC` or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_wp | input | 16 | Ring write pointer from the receiver; 0xFFFF marks it invalid |
| ptr_clear | input | 1 | Resets the read pointer to 0 |
| fetch_valid | output | 1 | Entry at `fetch_idx` is wanted |
| fetch_idx | output | 8 | Ring index of the next entry |
| fetch_ready | input | 1 | Ring side presents that entry this cycle |
| fetch_resp | input | 32 | Response word of the entry |
| fetch_ext | input | 32 | Extended tag word of the entry |
| cmd_valid | input | 1 | A command was issued to codec `cmd_addr` |
| cmd_addr | input | 4 | Codec address of the issued command |
| busy | output | NCODEC | Per-codec outstanding flag |
| res_sel | input | 4 | Codec whose result is read |
| res_data | output | 32 | Last stored result of that codec |
| evt_valid | output | 1 | Event queue is not empty |
| evt_ready | input | 1 | Consumer pops the head event |
| evt_resp | output | 32 | Head event response word |
| evt_ext | output | 32 | Head event extended word |
| resp_irq | output | 1 | One pulse per consumed entry |
| bad_addr_err | output | 1 | Pulse: entry had an out-of-range address |
| orphan_err | output | 1 | Pulse: solicited entry with no outstanding command |
| evt_drop | output | 1 | Pulse: event dropped because the queue was full |

Back-pressure rules:
- On the fetch side, the dispatcher holds `fetch_idx` until `fetch_ready`.
- On the event side, the head entry stays stable until `evt_ready`.
- The queue never stalls the ring. When it is full, events are lost instead.

## Verification
The embedded properties check the following on every cycle:
- The tag decode yields at most one route.
- A counter is only decremented while its codec is busy.
- A consumed entry is always followed by an interrupt pulse and by a pointer step to the fetched index.
- An invalid write pointer freezes the pointer.
- A push into a full queue always yields a drop pulse.

Only the bench's scenarios can show the following:
- Routing to the correct codec result.
- Event ordering and word content.
- The priority of a bad address over the event flag.
- The orphan case after counters run out.
- Recovery after `ptr_clear`.
- Wrap from index 255 to 0 under a stalling ring side.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  localparam int ADDR_W   = 4;   // codec address field, low bits of extended word
  localparam int EVT_BIT  = 4;   // event flag position in extended word
  localparam int WORD_W   = 32;

  typedef struct packed {
    logic [WORD_W-1:0] resp;
    logic [WORD_W-1:0] ext;
  } rrd_entry_t;
endpackage

// File: rtl/rrd_classify.sv
module rrd_classify
  import rrd_pkg::*;
#(
  parameter int NCODEC = 8
) (
  input  logic              take,
  input  logic [ADDR_W:0]   tag,
  input  logic [NCODEC-1:0] busy,
  output logic [ADDR_W-1:0] addr,
  output logic              go_evt,
  output logic              go_sol,
  output logic              go_bad,
  output logic              go_orph
);
  logic addr_ok;
  logic pending;

  assign addr    = tag[ADDR_W-1:0];
  assign addr_ok = int'(addr) < NCODEC;

  always_comb begin
    pending = 1'b0;
    for (int g = 0; g < NCODEC; g++) begin
      if (addr == ADDR_W'(g)) pending = busy[g];
    end
  end

  // priority: bad address, then event flag, then solicited match
  assign go_bad  = take && !addr_ok;
  assign go_evt  = take && addr_ok && tag[EVT_BIT];
  assign go_sol  = take && addr_ok && !tag[EVT_BIT] && pending;
  assign go_orph = take && addr_ok && !tag[EVT_BIT] && !pending;
endmodule

// File: rtl/rrd_codec_track.sv
module rrd_codec_track
  import rrd_pkg::*;
#(
  parameter int NCODEC = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [ADDR_W-1:0] inc_addr,
  input  logic              dec_en,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [WORD_W-1:0] dec_data,
  input  logic [ADDR_W-1:0] rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [NCODEC-1:0] busy
);
  logic [WORD_W-1:0] result_q [NCODEC];

  for (genvar g = 0; g < NCODEC; g++) begin : g_codec
    logic [CNT_W-1:0] cnt_q;
    logic inc_hit, dec_hit;

    assign inc_hit = inc_en && (inc_addr == ADDR_W'(g));
    assign dec_hit = dec_en && (dec_addr == ADDR_W'(g));
    assign busy[g] = cnt_q != '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q       <= '0;
        result_q[g] <= '0;
      end else begin
        case ({inc_hit, dec_hit})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
        if (dec_hit) result_q[g] <= dec_data;
      end
    end

    // R7: a matched answer is only taken while the codec has work outstanding
    assert_dec_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> cnt_q != '0);
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NCODEC; g++) begin
      if (rd_sel == ADDR_W'(g)) rd_data = result_q[g];
    end
  end
endmodule

// File: rtl/rrd_evt_fifo.sv
module rrd_evt_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_a, rd_a;
  logic [AW:0]   cnt;
  logic          full, push_ok, pop;

  assign full      = cnt == (AW+1)'(DEPTH);
  assign push_ok   = push && !full;
  assign out_valid = cnt != '0;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_a];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_a] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_a <= '0;
      rd_a <= '0;
      cnt  <= '0;
      drop <= 1'b0;
    end else begin
      drop <= push && full;
      if (push_ok) wr_a <= (wr_a == AW'(DEPTH-1)) ? '0 : wr_a + 1'b1;
      if (pop)     rd_a <= (rd_a == AW'(DEPTH-1)) ? '0 : rd_a + 1'b1;
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> drop);
  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(rd_a));
endmodule

// File: rtl/resp_ring_dispatch.sv
module resp_ring_dispatch
  import rrd_pkg::*;
#(
  parameter int NCODEC    = 8,
  parameter int CNT_W     = 4,
  parameter int PTR_W     = 8,
  parameter int WP_W      = 16,
  parameter int EVQ_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WP_W-1:0]   hw_wp,
  input  logic              ptr_clear,
  output logic              fetch_valid,
  output logic [PTR_W-1:0]  fetch_idx,
  input  logic              fetch_ready,
  input  logic [WORD_W-1:0] fetch_resp,
  input  logic [WORD_W-1:0] fetch_ext,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [NCODEC-1:0] busy,
  input  logic [ADDR_W-1:0] res_sel,
  output logic [WORD_W-1:0] res_data,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [WORD_W-1:0] evt_resp,
  output logic [WORD_W-1:0] evt_ext,
  output logic              resp_irq,
  output logic              bad_addr_err,
  output logic              orphan_err,
  output logic              evt_drop
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam int               ENT_W   = 2 * WORD_W;

  logic [PTR_W-1:0]  rd_ptr;
  logic              wp_dead, take;
  logic [ADDR_W-1:0] ent_addr;
  logic              go_evt, go_sol, go_bad, go_orph;
  rrd_entry_t        in_ent, head_ent;
  logic [ENT_W-1:0]  head_flat;

  assign wp_dead     = hw_wp == {WP_W{1'b1}};
  assign fetch_valid = !wp_dead && !ptr_clear && (rd_ptr != hw_wp[PTR_W-1:0]);
  assign fetch_idx   = rd_ptr + PTR_ONE;
  assign take        = fetch_valid && fetch_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr       <= '0;
      resp_irq     <= 1'b0;
      bad_addr_err <= 1'b0;
      orphan_err   <= 1'b0;
    end else begin
      if (ptr_clear)  rd_ptr <= '0;
      else if (take)  rd_ptr <= fetch_idx;
      resp_irq     <= take;
      bad_addr_err <= go_bad;
      orphan_err   <= go_orph;
    end
  end

  rrd_classify #(.NCODEC(NCODEC)) u_cls (
    .take    (take),
    .tag     (fetch_ext[ADDR_W:0]),
    .busy    (busy),
    .addr    (ent_addr),
    .go_evt  (go_evt),
    .go_sol  (go_sol),
    .go_bad  (go_bad),
    .go_orph (go_orph)
  );

  rrd_codec_track #(.NCODEC(NCODEC), .CNT_W(CNT_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (cmd_valid),
    .inc_addr (cmd_addr),
    .dec_en   (go_sol),
    .dec_addr (ent_addr),
    .dec_data (fetch_resp),
    .rd_sel   (res_sel),
    .rd_data  (res_data),
    .busy     (busy)
  );

  assign in_ent.resp = fetch_resp;
  assign in_ent.ext  = fetch_ext;

  rrd_evt_fifo #(.DEPTH(EVQ_DEPTH), .W(ENT_W)) u_evq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (go_evt),
    .push_data (in_ent),
    .out_valid (evt_valid),
    .out_ready (evt_ready),
    .out_data  (head_flat),
    .drop      (evt_drop)
  );

  assign head_ent = head_flat;
  assign evt_resp = head_ent.resp;
  assign evt_ext  = head_ent.ext;

  assert_single_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_evt, go_sol, go_bad, go_orph}));
  assert_irq_per_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> resp_irq);
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ptr_clear) |=> rd_ptr == $past(fetch_idx));
  assert_dead_wp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_dead && !ptr_clear) |=> $stable(rd_ptr));
endmodule

// File: tb/resp_ring_dispatch_test.sv
module resp_ring_dispatch_test;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_wp = 16'h0;
  logic        ptr_clear = 1'b0;
  logic        fetch_valid;
  logic [7:0]  fetch_idx;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_resp, fetch_ext;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_addr = 4'h0;
  logic [NC-1:0] busy;
  logic [3:0]  res_sel = 4'h0;
  logic [31:0] res_data;
  logic        evt_valid;
  logic        evt_ready = 1'b0;
  logic [31:0] evt_resp, evt_ext;
  logic        resp_irq, bad_addr_err, orphan_err, evt_drop;

  logic [31:0] ring_r [256];
  logic [31:0] ring_x [256];

  always #10 clk = ~clk;   // 50 MHz

  assign fetch_resp = ring_r[fetch_idx];
  assign fetch_ext  = ring_x[fetch_idx];

  resp_ring_dispatch uut (
    .clk(clk), .rst_n(rst_n), .hw_wp(hw_wp), .ptr_clear(ptr_clear),
    .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .fetch_ready(fetch_ready),
    .fetch_resp(fetch_resp), .fetch_ext(fetch_ext),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .busy(busy),
    .res_sel(res_sel), .res_data(res_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_resp(evt_resp), .evt_ext(evt_ext),
    .resp_irq(resp_irq), .bad_addr_err(bad_addr_err), .orphan_err(orphan_err),
    .evt_drop(evt_drop)
  );

  // ---------------- reference model ----------------
  int          m_rp;
  int          m_cnt [NC];
  logic [31:0] m_res [NC];
  logic [63:0] evq [$];
  bit          m_irq, m_bad, m_orph, m_drop;

  int checks = 0;
  int errors = 0;

  function automatic bit m_fetch_valid();
    return (hw_wp != 16'hFFFF) && !ptr_clear && (m_rp != int'(hw_wp[7:0]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rp = 0; evq.delete();
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_res[i] = 0; end
      m_irq = 0; m_bad = 0; m_orph = 0; m_drop = 0;
    end else begin
      bit hs, was_full;
      int a, idx, old_cnt [NC];
      for (int i = 0; i < NC; i++) old_cnt[i] = m_cnt[i];
      hs = m_fetch_valid() && fetch_ready;
      was_full = evq.size() == 16;
      m_irq = hs; m_bad = 0; m_orph = 0; m_drop = 0;
      if (evt_ready && evq.size() > 0) void'(evq.pop_front());
      if (cmd_valid && cmd_addr < NC) m_cnt[cmd_addr]++;
      if (hs) begin
        idx = (m_rp + 1) % 256;
        a = int'(ring_x[idx][3:0]);
        if (a >= NC) m_bad = 1;
        else if (ring_x[idx][4]) begin
          if (was_full) m_drop = 1;
          else evq.push_back({ring_r[idx], ring_x[idx]});
        end else if (old_cnt[a] > 0) begin
          m_res[a] = ring_r[idx];
          m_cnt[a]--;
        end else m_orph = 1;
      end
      if (ptr_clear) m_rp = 0;
      else if (hs) m_rp = (m_rp + 1) % 256;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NC-1:0] eb;
    logic [31:0] er;
    for (int i = 0; i < NC; i++) eb[i] = m_cnt[i] != 0;
    er = (res_sel < NC) ? m_res[res_sel] : 32'h0;
    chk(fetch_valid == m_fetch_valid(), "R2/R3", "fetch_valid", 64'(fetch_valid), 64'(m_fetch_valid()));
    chk(fetch_idx == 8'((m_rp + 1) % 256), "R2", "fetch_idx", 64'(fetch_idx), 64'((m_rp + 1) % 256));
    chk(busy == eb, "R8", "busy", 64'(busy), 64'(eb));
    chk(res_data == er, "R6/R12", "res_data", 64'(res_data), 64'(er));
    chk(evt_valid == (evq.size() > 0), "R5", "evt_valid", 64'(evt_valid), 64'(evq.size() > 0));
    if (evq.size() > 0)
      chk({evt_resp, evt_ext} == evq[0], "R5", "event head", {evt_resp, evt_ext}, evq[0]);
    chk(resp_irq == m_irq, "R9", "resp_irq", 64'(resp_irq), 64'(m_irq));
    chk(bad_addr_err == m_bad, "R4", "bad_addr_err", 64'(bad_addr_err), 64'(m_bad));
    chk(orphan_err == m_orph, "R7", "orphan_err", 64'(orphan_err), 64'(m_orph));
    chk(evt_drop == m_drop, "R10", "evt_drop", 64'(evt_drop), 64'(m_drop));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  int lfsr = 32'h1ACE;
  function automatic bit rbit();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
    return lfsr[0];
  endfunction

  task automatic drain_to(input int target, input bit rnd_ready);
    while (m_rp != target) begin
      fetch_ready = rnd_ready ? rbit() : 1'b1;
      tick();
    end
    fetch_ready = 1'b0;
    tick();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ring_r[i] = 32'h0; ring_x[i] = 32'h0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!fetch_valid && fetch_idx == 8'd1, "R1", "reset fetch", 64'(fetch_idx), 64'd1);
    chk(busy == '0 && !evt_valid, "R1", "reset busy/evt", 64'(busy), 64'd0);
    chk(!resp_irq && !bad_addr_err && !orphan_err && !evt_drop, "R1", "reset pulses",
        64'({resp_irq, bad_addr_err, orphan_err, evt_drop}), 64'd0);
    rst_n = 1'b1;
    tick();

    // Directed routing set (R4 R5 R6 R7)
    ring_r[1] = 32'hAAAA0001; ring_x[1] = 32'h2;
    ring_r[2] = 32'hAAAA0002; ring_x[2] = 32'h2;
    ring_r[3] = 32'h55550003; ring_x[3] = 32'h5;
    ring_r[4] = 32'h33330004; ring_x[4] = 32'h3;          // orphan
    ring_r[5] = 32'h99990005; ring_x[5] = 32'h9;          // bad address
    ring_r[6] = 32'hE0000006; ring_x[6] = 32'h11;         // event codec 1
    ring_r[7] = 32'hE0000007; ring_x[7] = 32'hABC00017;   // event, upper bits kept
    ring_r[8] = 32'hE0000008; ring_x[8] = 32'h19;         // bad beats event flag
    cmd_valid = 1'b1; cmd_addr = 4'd2; tick(); tick();
    cmd_addr = 4'd5; tick();
    cmd_addr = 4'd12; tick();                              // out of range: ignored
    cmd_valid = 1'b0; tick();
    res_sel = 4'd2; evt_ready = 1'b1;
    hw_wp = 16'd8;
    drain_to(8, 1'b1);
    for (int s = 0; s < 16; s++) begin
      res_sel = 4'(s); tick();   // R12 sweep includes out-of-range selects
    end

    // R3: invalid write pointer freezes fetching
    for (int i = 9; i <= 12; i++) begin ring_r[i] = 32'hC000_0000 + i; ring_x[i] = 32'h10 | (i % 8); end
    hw_wp = 16'hFFFF; fetch_ready = 1'b1;
    repeat (8) tick();
    hw_wp = 16'd12;
    drain_to(12, 1'b0);

    // R11: pointer clear, then refetch from index 1
    ptr_clear = 1'b1; tick();
    ptr_clear = 1'b0;
    chk(fetch_idx == 8'd1, "R11", "fetch_idx after clear", 64'(fetch_idx), 64'd1);
    drain_to(12, 1'b1);

    // R10: overflow with consumer stalled
    evt_ready = 1'b0;
    for (int i = 13; i <= 40; i++) begin ring_r[i] = 32'hD000_0000 + i; ring_x[i] = 32'h10 | (i % 8); end
    hw_wp = 16'd40;
    drain_to(40, 1'b0);
    evt_ready = 1'b1; fetch_ready = 1'b0;
    repeat (20) tick();

    // R8: issue and consume for one codec overlap
    for (int i = 41; i <= 46; i++) begin ring_r[i] = 32'h4400_0000 + i; ring_x[i] = 32'h4; end
    res_sel = 4'd4;
    cmd_valid = 1'b1; cmd_addr = 4'd4; tick();
    hw_wp = 16'd46;
    fetch_ready = 1'b1;
    repeat (4) tick();
    cmd_valid = 1'b0;
    drain_to(46, 1'b0);

    // R2: long run through the 255 -> 0 wrap with mixed classes
    for (int i = 47; i < 256 + 21; i++) begin
      int k;
      k = i % 256;
      ring_r[k] = 32'h7000_0000 ^ (32'(k) * 32'h01010101);
      case (i % 4)
        0: ring_x[k] = 32'h10 | 32'(k % 8);
        1: ring_x[k] = 32'(k % 8);
        2: ring_x[k] = 32'h8 | 32'(k % 8);
        default: ring_x[k] = 32'h5A00_0000 | 32'(k % 8);
      endcase
    end
    hw_wp = 16'h0014;   // index 20, beyond the wrap
    while (m_rp != 20) begin
      int c;
      fetch_ready = rbit();
      evt_ready = rbit();
      c = int'(lfsr[6:4]);
      cmd_valid = rbit() && (m_cnt[c] < 10);
      cmd_addr = 4'(c);
      res_sel = 4'(lfsr[11:8]);
      tick();
    end
    cmd_valid = 1'b0; fetch_ready = 1'b0; evt_ready = 1'b1;
    repeat (20) tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule